// File: doc/BRIEF.md
# Divider and Programmable Timer

This block keeps a free-running 8-bit divider and an 8-bit programmable counter. Both are driven from one shared prescaler, which advances on every machine-cycle tick. A tick is worth a fixed number of base clocks. When the double-speed flag is set, a tick is worth twice as many. The divider steps every 256 base clocks. The counter steps at one of four rates chosen by a 2-bit field, and only while its enable bit is set.

When the counter steps past 255 it loads the value held in the modulo register. One cycle later the block raises a single-cycle interrupt request, which the external interrupt-flag logic latches as request bit 2.

Software reaches four registers through one 2-bit select. Writes are synchronous. Reads are combinational on the same select. Any write to the divider clears the divider and the whole prescaler.

Top module: `tick_timer`

## Requirements
- R1: After reset the divider, counter, modulo and control registers all read 0, and irq_o is low.
- R2: A normal-speed tick advances the prescaler by 4 base clocks. The divider increments once per 256 base clocks (every 64 ticks), whatever the control register holds.
- R3: Control bits 1:0 set the counter period in base clocks: 0 gives 1024, 1 gives 16, 2 gives 64 and 3 gives 256.
- R4: Control bit 2 enables the counter. While it is 0 the counter holds its value.
- R5: With dbl_speed_i high, each tick advances the prescaler by 8 base clocks, so the divider and the counter both run twice as fast per tick.
- R6: When the counter steps from 255 it loads the modulo register value, not zero.
- R7: An overflow drives irq_o high for exactly one cycle. That cycle is the first one in which the reloaded value is visible.
- R8: A write to select 0, whatever the data, clears the divider and the prescaler. The next divider step then comes a full 64 normal ticks later.
- R9: A counter write in the same cycle as an overflow wins. The written value is stored, no reload occurs and no interrupt pulse is raised.
- R10: The register select works as follows: 0 is the divider, 1 the counter, 2 the modulo and 3 the control. Control reads back its bits 2:0 with the upper bits zero.
- R11: In a cycle with neither a tick nor a write, the divider and the counter do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Machine-cycle tick |
| dbl_speed_i | input | 1 | Double-speed mode |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register select for read and write |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data of the selected register |
| irq_o | output | 1 | One-cycle timer interrupt request |

## Verification
Two functions can land in the same clock edge: a software write to the counter and the tick that carries the counter past 255.

The bench provokes the collision as follows. It loads 255 at the fastest rate, gives three ticks, and then drives the fourth tick together with the write. It judges the outcome by reading back the written value and by confirming that irq_o stays low.

A separate run without the write checks that the same tick produces the modulo reload and a pulse of exactly one cycle.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;
  localparam int PRE_W   = 10;  // prescaler bits, slowest period 2**PRE_W
  localparam int N_RATE  = 4;
  localparam int DIV_TAP = 8;   // divider period 2**DIV_TAP base clocks

  typedef enum logic [1:0] {
    SEL_DIV = 2'd0,
    SEL_CNT = 2'd1,
    SEL_MOD = 2'd2,
    SEL_CTL = 2'd3
  } reg_sel_e;

  // rate code -> prescaler carry bit (period = 2**tap)
  function automatic int rate_tap(input int code);
    case (code)
      0:       return PRE_W;
      1:       return 4;
      2:       return 6;
      default: return 8;
    endcase
  endfunction
endpackage

// File: rtl/tick_timer_prescale.sv
module tick_timer_prescale
  import tick_timer_pkg::*;
#(
  parameter int STEP_LOG2 = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              dbl_i,
  input  logic              clr_i,
  output logic [N_RATE-1:0] rate_hit_o,
  output logic              div_hit_o
);
  localparam int SW = PRE_W + 1;
  localparam logic [SW-1:0] STEP_N = SW'(1 << STEP_LOG2);
  localparam logic [SW-1:0] STEP_D = SW'(2 << STEP_LOG2);

  logic [PRE_W-1:0] pre_q;
  logic [SW-1:0]    step;
  logic             adv;

  assign step = dbl_i ? STEP_D : STEP_N;
  assign adv  = tick_i && !clr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pre_q <= '0;
    else if (clr_i)  pre_q <= '0;
    else if (tick_i) pre_q <= pre_q + step[PRE_W-1:0];
  end

  // carry into bit TAP: low bits plus step reach 2**TAP
  for (genvar r = 0; r < N_RATE; r++) begin : g_rate
    localparam int TAP = rate_tap(r);
    localparam logic [SW-1:0] MASK = SW'((1 << TAP) - 1);
    localparam logic [SW-1:0] LIM  = SW'(1 << TAP);
    logic [SW-1:0] low;
    assign low           = {1'b0, pre_q} & MASK;
    assign rate_hit_o[r] = adv && ((low + step) >= LIM);
  end

  localparam logic [SW-1:0] DMASK = SW'((1 << DIV_TAP) - 1);
  localparam logic [SW-1:0] DLIM  = SW'(1 << DIV_TAP);
  logic [SW-1:0] dlow;
  assign dlow      = {1'b0, pre_q} & DMASK;
  assign div_hit_o = adv && ((dlow + step) >= DLIM);
endmodule

// File: rtl/tick_timer_div.sv
module tick_timer_div #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hit_i,
  input  logic              clr_i,
  output logic [DATA_W-1:0] div_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    div_o <= '0;
    else if (clr_i) div_o <= '0;
    else if (hit_i) div_o <= div_o + 1'b1;
  end
endmodule

// File: rtl/tick_timer_cnt.sv
module tick_timer_cnt #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              inc_i,
  input  logic              wr_cnt_i,
  input  logic              wr_mod_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] cnt_o,
  output logic [DATA_W-1:0] mod_o,
  output logic              irq_o
);
  localparam logic [DATA_W-1:0] TOP = '1;

  logic ovf;
  assign ovf = inc_i && (cnt_o == TOP);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o <= '0;
      mod_o <= '0;
      irq_o <= 1'b0;
    end else begin
      if (wr_cnt_i)   cnt_o <= wdata_i;      // write beats reload
      else if (ovf)   cnt_o <= mod_o;
      else if (inc_i) cnt_o <= cnt_o + 1'b1;
      if (wr_mod_i)   mod_o <= wdata_i;
      irq_o <= ovf && !wr_cnt_i;
    end
  end
endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tick_timer_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int STEP_LOG2 = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              dbl_speed_i,
  input  logic              wr_en_i,
  input  logic [1:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  localparam int CTL_W = 3;

  logic [CTL_W-1:0]  ctl_w;
  logic [DATA_W-1:0] div_w, cnt_w, mod_w;
  logic [N_RATE-1:0] rate_hit;
  logic              div_hit, wr_div, wr_cnt, wr_mod, wr_ctl, cnt_inc;
  reg_sel_e          sel;

  assign sel    = reg_sel_e'(addr_i);
  assign wr_div = wr_en_i && (sel == SEL_DIV);
  assign wr_cnt = wr_en_i && (sel == SEL_CNT);
  assign wr_mod = wr_en_i && (sel == SEL_MOD);
  assign wr_ctl = wr_en_i && (sel == SEL_CTL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ctl_w <= '0;
    else if (wr_ctl) ctl_w <= wdata_i[CTL_W-1:0];
  end

  tick_timer_prescale #(.STEP_LOG2(STEP_LOG2)) u_pre (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick_i),
    .dbl_i      (dbl_speed_i),
    .clr_i      (wr_div),
    .rate_hit_o (rate_hit),
    .div_hit_o  (div_hit)
  );

  tick_timer_div #(.DATA_W(DATA_W)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .hit_i  (div_hit),
    .clr_i  (wr_div),
    .div_o  (div_w)
  );

  assign cnt_inc = ctl_w[2] && rate_hit[ctl_w[1:0]];

  tick_timer_cnt #(.DATA_W(DATA_W)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .inc_i    (cnt_inc),
    .wr_cnt_i (wr_cnt),
    .wr_mod_i (wr_mod),
    .wdata_i  (wdata_i),
    .cnt_o    (cnt_w),
    .mod_o    (mod_w),
    .irq_o    (irq_o)
  );

  always_comb begin
    case (sel)
      SEL_DIV: rdata_o = div_w;
      SEL_CNT: rdata_o = cnt_w;
      SEL_MOD: rdata_o = mod_w;
      default: rdata_o = {{(DATA_W-CTL_W){1'b0}}, ctl_w};
    endcase
  end
endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tick_i,
  input logic              wr_en_i,
  input logic [1:0]        addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic              irq_o,
  input logic [2:0]        ctl_w,
  input logic [DATA_W-1:0] div_w,
  input logic [DATA_W-1:0] cnt_w,
  input logic [DATA_W-1:0] mod_w
);
  p_irq_single_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);

  p_reload_mod_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> cnt_w == $past(mod_w));

  p_hold_off_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctl_w[2] && !(wr_en_i && addr_i == 2'd1)) |=> $stable(cnt_w));

  p_div_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == 2'd0) |=> div_w == '0);

  p_cnt_wr_wins_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == 2'd1) |=> (cnt_w == $past(wdata_i)) && !irq_o);

  p_idle_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !wr_en_i) |=> $stable(div_w) && $stable(cnt_w));
endmodule

bind tick_timer tick_timer_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .tick_i  (tick_i),
  .wr_en_i (wr_en_i),
  .addr_i  (addr_i),
  .wdata_i (wdata_i),
  .irq_o   (irq_o),
  .ctl_w   (ctl_w),
  .div_w   (div_w),
  .cnt_w   (cnt_w),
  .mod_w   (mod_w)
);

// File: tb/tick_timer_test.sv
`timescale 1ns/1ps
module tick_timer_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0, dbl = 1'b0, wr = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic       irq;
  int total = 0, bad = 0;

  always #4 clk = ~clk;  // 125 MHz

  tick_timer uut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .dbl_speed_i(dbl),
    .wr_en_i(wr), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  // {ctl, dbl, ticks, exp_cnt, exp_div}
  localparam int NV = 7;
  localparam logic [47:0] VEC [NV] = '{
    48'h04_00_0258_02_09,  // R3 rate 0: 1024
    48'h05_00_0064_19_01,  // R3 rate 1: 16
    48'h06_00_0064_06_01,  // R3 rate 2: 64
    48'h07_00_012C_04_04,  // R3 rate 3: 256
    48'h05_01_0064_32_03,  // R5 double speed
    48'h01_00_012C_00_04,  // R4 disabled, divider runs
    48'h07_01_0040_02_02   // R5 double speed, slow rate
  };

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%02h exp=%02h", req, got, exp);
    end
  endtask

  task automatic step(input logic t, input logic w, input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    tick = t; wr = w; addr = a; wdata = d;
    @(posedge clk);
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) step(1'b1, 1'b0, 2'd0, 8'd0);
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk);
    tick = 1'b0; wr = 1'b0; addr = a;
    #1 v = rdata;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), v); chk("R1 reset reg", v, 8'h00);
    end
    chk("R1 reset irq", {7'd0, irq}, 8'h00);

    // R10 select map and control readback
    step(1'b0, 1'b1, 2'd3, 8'hFD);
    rd(2'd3, v); chk("R10 ctl readback", v, 8'h05);
    step(1'b0, 1'b1, 2'd2, 8'h5C);
    rd(2'd2, v); chk("R10 mod readback", v, 8'h5C);

    // vector table: R2 R3 R4 R5
    for (int k = 0; k < NV; k++) begin
      step(1'b0, 1'b1, 2'd0, 8'h00);
      step(1'b0, 1'b1, 2'd1, 8'h00);
      step(1'b0, 1'b1, 2'd3, VEC[k][47:40]);
      dbl = VEC[k][32];
      run(int'(VEC[k][31:16]));
      rd(2'd1, v); chk("R3/R4/R5 counter", v, VEC[k][15:8]);
      rd(2'd0, v); chk("R2/R5 divider", v, VEC[k][7:0]);
    end
    dbl = 1'b0;

    // R11 idle cycles change nothing (ctl=7, cnt=2, div=2 from last vector)
    for (int i = 0; i < 10; i++) step(1'b0, 1'b0, 2'd0, 8'd0);
    rd(2'd1, v); chk("R11 counter idle", v, 8'h02);
    rd(2'd0, v); chk("R11 divider idle", v, 8'h02);

    // R6 R7 overflow reload and pulse
    step(1'b0, 1'b1, 2'd0, 8'h00);
    step(1'b0, 1'b1, 2'd2, 8'hA0);
    step(1'b0, 1'b1, 2'd1, 8'hFE);
    step(1'b0, 1'b1, 2'd3, 8'h05);
    run(7);
    rd(2'd1, v); chk("R6 pre-overflow count", v, 8'hFF);
    chk("R7 no early irq", {7'd0, irq}, 8'h00);
    run(1);
    rd(2'd1, v); chk("R6 reload from modulo", v, 8'hA0);
    chk("R7 irq pulse", {7'd0, irq}, 8'h01);
    step(1'b0, 1'b0, 2'd0, 8'd0);
    rd(2'd1, v);
    chk("R7 irq one cycle", {7'd0, irq}, 8'h00);

    // R9 counter write collides with overflow
    step(1'b0, 1'b1, 2'd0, 8'h00);
    step(1'b0, 1'b1, 2'd1, 8'hFF);
    run(3);
    step(1'b1, 1'b1, 2'd1, 8'h33);
    rd(2'd1, v); chk("R9 write wins", v, 8'h33);
    chk("R9 irq suppressed", {7'd0, irq}, 8'h00);

    // R8 divider clear also clears prescaler (4 + 70 ticks -> div 1)
    run(70);
    rd(2'd0, v); chk("R2 divider step", v, 8'h01);
    step(1'b0, 1'b1, 2'd0, 8'h5A);
    rd(2'd0, v); chk("R8 divider cleared", v, 8'h00);
    run(63);
    rd(2'd0, v); chk("R8 prescaler cleared", v, 8'h00);
    run(1);
    rd(2'd0, v); chk("R8 first step after clear", v, 8'h01);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule